// File: doc/BRIEF.md
# Selectable Pixel Format Packer

This block accepts 8-bit-per-channel pixels (alpha, red, green, blue) over a valid/ready handshake. It converts each pixel into one of twelve memory layouts chosen by a 4-bit code, then packs the converted bytes into 32-bit words. Each word carries a 4-bit byte-lane strobe, and the words leave the block on a second valid/ready handshake. The layouts are 16-bit 4444, 16-bit 565, 24-bit 888 and 32-bit 8888, and each comes in several channel orders. The 24-bit layouts pack densely, so one pixel can span two words.

The alpha slot can hold the incoming alpha, its bitwise inverse, or a constant fill. A 4-bit lane mask applies to every output word and clears the strobes of unwanted byte lanes. An end-of-line marker that travels with the last pixel of a row flushes any partly filled word. Selecting an unused code stalls the input and raises an error flag.

Top module: `pix_packer`

## Requirements
- R1: After reset, `out_valid` is 0, and `in_ready` is 1 whenever a defined format code is selected.
- R2: Codes 12 ABGR, 13 ARGB, 14 BGRA and 15 RGBA give one full 32-bit word per pixel. The named channels run from bit 31 down to bit 0, so for code 13 alpha is in bits 31:24 and blue in bits 7:0.
- R3: Codes 8 (BGR) and 9 (RGB) give 3 bytes per pixel, least significant byte first, packed densely into words from lane 0 upward. Four pixels fill exactly three words.
- R4: Codes 6 (BGR565) and 7 (RGB565) keep the top 5, 6 and 5 bits of the channels, highest-named channel in bits 15:11. Two pixels share one word, and the earlier pixel is in bits 15:0.
- R5: Codes 0 ABGR4444, 1 ARGB4444, 2 BGRA4444 and 3 RGBA4444 keep the top 4 bits of each channel, highest-named channel in bits 15:12. Two pixels share one word, and the earlier pixel is in the low half.
- R6: When `alpha_keep` is 0, every bit of the alpha slot equals the inverse of `alpha_inv`.
- R7: When `alpha_keep` is 1, the alpha slot holds the incoming alpha, bitwise inverted when `alpha_inv` is 1.
- R8: Bit k of `lane_mask` gates bit k of `out_strb` in every word. Code 4'hF leaves all filled lanes enabled.
- R9: Codes 4, 5, 10 and 11 are reserved. While one is selected, `fmt_err` is 1, `in_ready` is 0 and no new word is produced.
- R10: A pixel accepted with `in_eol` flushes the partial word. Only the filled lanes have their strobes set. When a 24-bit pixel overruns a word, a second, partial word follows.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_strb` hold their values.
- R12: A word completed by a pixel accepted on a rising edge is presented on `out_valid` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 4 | Format code |
| alpha_keep | input | 1 | Store incoming alpha (1) or fill (0) |
| alpha_inv | input | 1 | Invert stored alpha / select fill value |
| lane_mask | input | 4 | Per-lane strobe gate |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 32 | Pixel {alpha, red, green, blue} |
| in_eol | input | 1 | Pixel is the last of its line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Packed word |
| out_strb | output | 4 | Byte-lane strobes |
| fmt_err | output | 1 | Reserved code selected |

## Verification
The output word is registered, so a word that one pixel completes is valid just after the edge that accepts that pixel. A flush word that follows a 24-bit overrun comes one transfer slot later. The bench drives inputs half a period away from the rising edge. It predicts each word into a queue when it hands a pixel to the block, and a monitor compares the words in order at each falling edge where `out_valid` and `out_ready` are both high, so no word is checked earlier than it can exist. One test checks the single-cycle latency directly at the first falling edge after acceptance. Stall stability is checked one cycle after each refused transfer.

// File: rtl/pix_packer.sv
module pix_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  fmt,
  input  logic        alpha_keep,
  input  logic        alpha_inv,
  input  logic [3:0]  lane_mask,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_pix,
  input  logic        in_eol,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [3:0]  out_strb,
  output logic        fmt_err
);

  logic [55:0] acc_q;
  logic [2:0]  cnt_q;
  logic        flush_q;
  logic        ov_q;
  logic [31:0] od_q;
  logic [3:0]  os_q;

  logic [7:0]  av, rv, gv, bv;
  logic [31:0] px;
  logic [2:0]  nb;

  assign rv = in_pix[23:16];
  assign gv = in_pix[15:8];
  assign bv = in_pix[7:0];
  assign av = alpha_keep ? (in_pix[31:24] ^ {8{alpha_inv}}) : {8{~alpha_inv}};

  always_comb begin
    px = '0;
    nb = 3'd0;
    case (fmt)
      4'd0:  begin px = {16'd0, av[7:4], bv[7:4], gv[7:4], rv[7:4]}; nb = 3'd2; end
      4'd1:  begin px = {16'd0, av[7:4], rv[7:4], gv[7:4], bv[7:4]}; nb = 3'd2; end
      4'd2:  begin px = {16'd0, bv[7:4], gv[7:4], rv[7:4], av[7:4]}; nb = 3'd2; end
      4'd3:  begin px = {16'd0, rv[7:4], gv[7:4], bv[7:4], av[7:4]}; nb = 3'd2; end
      4'd6:  begin px = {16'd0, bv[7:3], gv[7:2], rv[7:3]}; nb = 3'd2; end
      4'd7:  begin px = {16'd0, rv[7:3], gv[7:2], bv[7:3]}; nb = 3'd2; end
      4'd8:  begin px = {8'd0, bv, gv, rv}; nb = 3'd3; end
      4'd9:  begin px = {8'd0, rv, gv, bv}; nb = 3'd3; end
      4'd12: begin px = {av, bv, gv, rv}; nb = 3'd4; end
      4'd13: begin px = {av, rv, gv, bv}; nb = 3'd4; end
      4'd14: begin px = {bv, gv, rv, av}; nb = 3'd4; end
      4'd15: begin px = {rv, gv, bv, av}; nb = 3'd4; end
      default: begin px = '0; nb = 3'd0; end
    endcase
  end

  assign fmt_err = (nb == 3'd0);

  logic        slot_free, in_fire;
  logic [55:0] merged;
  logic [2:0]  nf;

  assign slot_free = !ov_q || out_ready;
  assign in_ready  = slot_free && !flush_q && !fmt_err;
  assign in_fire   = in_valid && in_ready;
  assign merged    = acc_q | ({24'd0, px} << {cnt_q, 3'b000});
  assign nf        = cnt_q + nb;

  function automatic logic [3:0] lanes(input logic [2:0] n);
    case (n)
      3'd1:    lanes = 4'b0001;
      3'd2:    lanes = 4'b0011;
      3'd3:    lanes = 4'b0111;
      3'd0:    lanes = 4'b0000;
      default: lanes = 4'b1111;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
      ov_q    <= 1'b0;
      od_q    <= '0;
      os_q    <= '0;
    end else if (flush_q && slot_free) begin
      ov_q    <= 1'b1;
      od_q    <= acc_q[31:0];
      os_q    <= lanes(cnt_q) & lane_mask;
      acc_q   <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else if (in_fire) begin
      if (nf >= 3'd4) begin
        ov_q    <= 1'b1;
        od_q    <= merged[31:0];
        os_q    <= lane_mask;
        acc_q   <= {32'd0, merged[55:32]};
        cnt_q   <= nf - 3'd4;
        flush_q <= in_eol && (nf > 3'd4);
      end else if (in_eol) begin
        ov_q  <= 1'b1;
        od_q  <= merged[31:0];
        os_q  <= lanes(nf) & lane_mask;
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        if (out_ready) ov_q <= 1'b0;
        acc_q <= merged;
        cnt_q <= nf;
      end
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_strb  = os_q;

endmodule

// File: rtl/pix_packer_chk.sv
module pix_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  fmt,
  input logic        alpha_keep,
  input logic        alpha_inv,
  input logic [3:0]  lane_mask,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic [3:0]  out_strb,
  input logic        fmt_err
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_strb)); // R11

  AST_RESERVED_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> !in_ready); // R9

  AST_WIDE_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && fmt[3:2] == 2'b11 |=> out_valid && out_strb == $past(lane_mask)); // R12

  AST_ALPHA_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && fmt == 4'd13 && !alpha_keep |=> out_data[31:24] == {8{~$past(alpha_inv)}}); // R6

endmodule

bind pix_packer pix_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt(fmt), .alpha_keep(alpha_keep), .alpha_inv(alpha_inv),
  .lane_mask(lane_mask), .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_strb(out_strb), .fmt_err(fmt_err)
);

// File: tb/sim_pix_packer.sv
module sim_pix_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fmt = 4'd13;
  logic        alpha_keep = 1'b1, alpha_inv = 1'b0;
  logic [3:0]  lane_mask = 4'hF;
  logic        in_valid = 1'b0, in_eol = 1'b0;
  logic [31:0] in_pix = '0;
  logic        in_ready, out_valid, fmt_err;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [3:0]  out_strb;

  always #5 clk = ~clk;

  pix_packer u0 (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .alpha_keep(alpha_keep), .alpha_inv(alpha_inv),
    .lane_mask(lane_mask), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_strb(out_strb), .fmt_err(fmt_err)
  );

  int n_chk = 0, n_bad = 0;
  logic [35:0] expq[$];
  logic [7:0]  pend[$];
  string       tag = "R2";
  bit          bp = 1'b0;
  logic [7:0]  lfsr = 8'h5A;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] p, input bit eol);
    logic [7:0] a, r, g, b;
    logic [31:0] v;
    int n;
    logic [31:0] w;
    logic [3:0] s;
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    if (alpha_keep) a = alpha_inv ? ~p[31:24] : p[31:24];
    else a = alpha_inv ? 8'h00 : 8'hFF;
    n = 2;
    case (fmt)
      4'd0: v = {16'd0, a[7:4], b[7:4], g[7:4], r[7:4]};
      4'd1: v = {16'd0, a[7:4], r[7:4], g[7:4], b[7:4]};
      4'd2: v = {16'd0, b[7:4], g[7:4], r[7:4], a[7:4]};
      4'd3: v = {16'd0, r[7:4], g[7:4], b[7:4], a[7:4]};
      4'd6: v = {16'd0, b[7:3], g[7:2], r[7:3]};
      4'd7: v = {16'd0, r[7:3], g[7:2], b[7:3]};
      4'd8: begin v = {8'd0, b, g, r}; n = 3; end
      4'd9: begin v = {8'd0, r, g, b}; n = 3; end
      4'd12: begin v = {a, b, g, r}; n = 4; end
      4'd13: begin v = {a, r, g, b}; n = 4; end
      4'd14: begin v = {b, g, r, a}; n = 4; end
      default: begin v = {r, g, b, a}; n = 4; end
    endcase
    for (int i = 0; i < n; i++) pend.push_back(v[8*i +: 8]);
    while (pend.size() >= 4) begin
      w = '0;
      for (int i = 0; i < 4; i++) w[8*i +: 8] = pend.pop_front();
      expq.push_back({lane_mask, w});
    end
    if (eol && pend.size() > 0) begin
      w = '0; s = '0;
      for (int i = 0; pend.size() > 0; i++) begin
        w[8*i +: 8] = pend.pop_front();
        s[i] = 1'b1;
      end
      expq.push_back({s & lane_mask, w});
    end
  endfunction

  task automatic put(input logic [31:0] p, input bit eol);
    @(negedge clk);
    in_pix = p; in_eol = eol; in_valid = 1'b1;
    model(p, eol);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_eol = 1'b0;
  endtask

  task automatic line(input int len, input int seed);
    for (int i = 0; i < len; i++) put(32'h9E3779B9 * (i + seed) ^ 32'h1357ACE0, i == len - 1);
  endtask

  task automatic drain;
    int t = 0;
    while ((expq.size() > 0 || out_valid) && t < 200) begin @(negedge clk); t++; end
    #3;
  endtask

  bit          prev_stall = 1'b0;
  logic [35:0] prev_word;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp ? lfsr[0] : 1'b1;
    #2;
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && {out_strb, out_data} == prev_word, "R11", {out_strb, out_data}, prev_word);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(1'b0, tag, {out_strb, out_data}, '0);
        else begin
          logic [35:0] e;
          e = expq.pop_front();
          check({out_strb, out_data} == e, tag, {out_strb, out_data}, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_word = {out_strb, out_data};
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    check(!out_valid && in_ready, "R1", {34'd0, out_valid, in_ready}, 36'd1);

    // R12: one-cycle latency for a full-word pixel
    fmt = 4'd13;
    @(negedge clk);
    in_pix = 32'h11223344; in_valid = 1'b1; model(32'h11223344, 1'b0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk); #1;
    check(out_valid && out_data == 32'h11223344, "R12", {3'd0, out_valid, out_data}, {3'd0, 1'b1, 32'h11223344});
    drain();

    tag = "R2";
    for (int f = 12; f < 16; f++) begin fmt = f[3:0]; line(3, f); drain(); end
    tag = "R3";
    fmt = 4'd9; line(4, 1); drain(); line(5, 2); drain();
    fmt = 4'd8; line(4, 3); drain(); line(7, 4); drain();
    tag = "R4";
    fmt = 4'd6; line(4, 5); drain(); fmt = 4'd7; line(5, 6); drain();
    tag = "R5";
    for (int f = 0; f < 4; f++) begin fmt = f[3:0]; line(3, 10 + f); drain(); end
    tag = "R6";
    fmt = 4'd13; alpha_keep = 1'b0; alpha_inv = 1'b0; line(2, 20); drain();
    alpha_inv = 1'b1; line(2, 21); drain();
    fmt = 4'd3; line(3, 22); drain();
    tag = "R7";
    alpha_keep = 1'b1; alpha_inv = 1'b1; fmt = 4'd14; line(2, 23); drain();
    fmt = 4'd1; line(2, 24); drain();
    alpha_inv = 1'b0;
    tag = "R8";
    lane_mask = 4'b0101; fmt = 4'd9; line(5, 30); drain();
    lane_mask = 4'b1000; fmt = 4'd7; line(3, 31); drain();
    lane_mask = 4'hF;
    tag = "R10";
    fmt = 4'd8; line(6, 40); drain(); line(1, 41); drain();
    fmt = 4'd6; line(1, 42); drain();

    tag = "R9";
    fmt = 4'd5;
    @(negedge clk); in_valid = 1'b1; in_pix = 32'hDEADBEEF;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #3;
      check(fmt_err && !in_ready && !out_valid, "R9", {33'd0, fmt_err, in_ready, out_valid}, 36'd4);
    end
    fmt = 4'd10; #1;
    check(fmt_err && !in_ready, "R9", {34'd0, fmt_err, in_ready}, 36'd2);
    @(negedge clk); in_valid = 1'b0;

    tag = "R11";
    bp = 1'b1;
    fmt = 4'd8; line(9, 50); drain();
    fmt = 4'd15; line(6, 51); drain();
    fmt = 4'd6; line(7, 52); drain();
    bp = 1'b0;
    drain();
    check(expq.size() == 0, "R10", expq.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule